// File: doc/BRIEF.md
# Shadow Image Flash Commit Sequencer

This block keeps a shadow copy of non-volatile configuration words and commits it to a flash store when software asks. Software writes the shadow image through a plain write port, then sets a request bit in a 32-bit control/status word. A hardware sequencer then runs the guarded commit. It waits until the flash reports done, issues the commit, and waits for done again. A copy engine moves every shadow word into the flash store, one word per clock. The done bit drops while the copy runs and comes back once the last word has landed.

Each wait for done samples the status at a fixed spacing of `POLL_INTERVAL` clocks and gives up after `POLL_LIMIT` samples. Giving up sets a sticky timeout error. A timeout in the first wait means nothing is committed. When the revision input is zero and the second-sector-valid input is high, the block commits the image a second time and waits a third time. An external hold input models a flash that is busy elsewhere. While hold is high, done reads 0 and the copy stalls. The flash store is a simple synchronous memory with its own read port.

Top module: `flash_commit_seq`

## Requirements
- R1: After reset the control/status word reads bit 26 (done) = 1, bit 23 (request) = 0, bit 24 (busy) = 0 and bit 28 (timeout error) = 0. The `busy`, `complete` and `timeout_err` outputs are low.
- R2: Writing 1 to bit 23 while idle starts an operation. Bit 23 reads 1 from the cycle after the write until the copy is started, and reads 0 from then on. `busy` is high while the sequencer is not idle.
- R3: A successful commit writes shadow word k to flash address k for every k below DEPTH. Bit 26 reads 0 while the copy runs and reads 1 after it. `complete` pulses high for exactly one cycle, after which the block is idle.
- R4: If done reads 0 at every sample of the first wait, the operation ends with `timeout_err` set. No copy is started, done never falls, the flash keeps its old contents and `complete` does not pulse.
- R5: A wait samples done once on entry and then every POLL_INTERVAL cycles, for at most POLL_LIMIT samples. A first-wait timeout therefore keeps `busy` high for exactly (POLL_LIMIT-1)*POLL_INTERVAL+1 cycles.
- R6: If done does not return within the second wait (for example, `fl_hold` raised during the copy), `timeout_err` is set and `complete` does not pulse. The stalled copy resumes when hold is released, and the image still arrives whole.
- R7: When `rev_id` is 0 and `sec1_valid` (mirrored on bit 25) is high at the end of the second wait, the commit is issued a second time, so done falls twice in one operation. With any other `rev_id`, or with `sec1_valid` low, the commit is issued only once.
- R8: `timeout_err` (bit 28) stays set until a write with bit 28 = 1. A write with bit 28 = 0 leaves it set.
- R9: A write of 1 to bit 23 while `busy` is high is ignored. No further operation follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Write data (bit 23 request, bit 28 error clear) |
| csr_rdata | output | 32 | Control/status word read value |
| sh_we | input | 1 | Shadow RAM write enable |
| sh_addr | input | AW | Shadow RAM write address |
| sh_wdata | input | DW | Shadow RAM write data |
| fl_raddr | input | AW | Flash store read address |
| fl_rdata | output | DW | Flash store read data, one cycle after the address |
| fl_hold | input | 1 | Flash busy elsewhere: forces done low and stalls the copy |
| rev_id | input | REV_W | Silicon revision number |
| sec1_valid | input | 1 | Second-sector-valid status flag |
| busy | output | 1 | Sequencer active |
| complete | output | 1 | One-cycle pulse on a successful commit |
| timeout_err | output | 1 | Sticky poll timeout error |

## Verification
The bench builds the block with DEPTH = 8, POLL_INTERVAL = 4 and POLL_LIMIT = 4. With these values a whole image copies in eight cycles, which fits inside the thirteen-cycle window of a single wait. A hold raised after the first copied word then pushes the second wait past its limit. Exact busy-cycle counts are small enough to compare against the R5 formula. Every flash word can be read back after each commit, and the revision-zero double commit shows up as two falls of the done bit within one operation.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int CSR_W    = 32;
  localparam int REQ_BIT  = 23;
  localparam int BUSY_BIT = 24;
  localparam int SEC1_BIT = 25;
  localparam int DONE_BIT = 26;
  localparam int ERR_BIT  = 28;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PRE   = 2'd1,
    SQ_ISSUE = 2'd2,
    SQ_POST  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/flc_mem.sv
module flc_mem #(
  parameter int DW     = 16,
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter bit REG_RD = 1'b0
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  generate
    if (REG_RD) begin : g_sync_rd
      logic [DW-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= mem_q[rd_addr];
      assign rd_data = rd_q;
    end else begin : g_comb_rd
      assign rd_data = mem_q[rd_addr];
    end
  endgenerate
endmodule

// File: rtl/flc_copy_engine.sv
module flc_copy_engine #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hold,
  output logic [AW-1:0] addr,
  output logic          wr_en,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          active_q, active_d;
  logic          done_q, done_d;
  logic [AW-1:0] addr_q, addr_d;

  assign wr_en = active_q & ~hold;

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    addr_d   = addr_q;
    if (start) begin
      active_d = 1'b1;
      done_d   = 1'b0;
      addr_d   = '0;
    end else if (wr_en) begin
      if (addr_q == LAST) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b1;
      addr_q   <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      addr_q   <= addr_d;
    end
  end

  assign addr = addr_q;
  assign done = done_q;
endmodule

// File: rtl/flc_poll_seq.sv
module flc_poll_seq
  import flc_pkg::*;
#(
  parameter int POLL_INTERVAL = 250,
  parameter int POLL_LIMIT    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pend,
  input  logic done_sts,
  input  logic rev_zero,
  input  logic sec1,
  output logic start,
  output logic clr_req,
  output logic busy,
  output logic complete,
  output logic timeout_set
);
  localparam int IV_W = $clog2(POLL_INTERVAL + 1);
  localparam int AT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [IV_W-1:0] IV_RELOAD = IV_W'(POLL_INTERVAL - 1);
  localparam logic [AT_W-1:0] AT_LAST   = AT_W'(POLL_LIMIT - 1);

  seq_st_e         st_q, st_d;
  logic [IV_W-1:0] ivl_q, ivl_d;
  logic [AT_W-1:0] att_q, att_d;
  logic            pass2_q, pass2_d;

  always_comb begin
    st_d        = st_q;
    ivl_d       = ivl_q;
    att_d       = att_q;
    pass2_d     = pass2_q;
    start       = 1'b0;
    clr_req     = 1'b0;
    complete    = 1'b0;
    timeout_set = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (req_pend) begin
          st_d    = SQ_PRE;
          ivl_d   = '0;
          att_d   = '0;
          pass2_d = 1'b0;
        end
      end
      SQ_ISSUE: begin
        start   = 1'b1;
        clr_req = 1'b1;
        st_d    = SQ_POST;
        ivl_d   = '0;
        att_d   = '0;
      end
      default: begin
        if (ivl_q != '0) begin
          ivl_d = ivl_q - 1'b1;
        end else if (done_sts) begin
          if (st_q == SQ_PRE) begin
            st_d = SQ_ISSUE;
          end else if (rev_zero && sec1 && !pass2_q) begin
            st_d    = SQ_ISSUE;
            pass2_d = 1'b1;
          end else begin
            complete = 1'b1;
            st_d     = SQ_IDLE;
          end
        end else if (att_q == AT_LAST) begin
          timeout_set = 1'b1;
          clr_req     = (st_q == SQ_PRE);
          st_d        = SQ_IDLE;
        end else begin
          att_d = att_q + 1'b1;
          ivl_d = IV_RELOAD;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      ivl_q   <= '0;
      att_q   <= '0;
      pass2_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ivl_q   <= ivl_d;
      att_q   <= att_d;
      pass2_q <= pass2_d;
    end
  end

  assign busy = (st_q != SQ_IDLE);
endmodule

// File: rtl/flash_commit_seq.sv
module flash_commit_seq
  import flc_pkg::*;
#(
  parameter int DW            = 16,
  parameter int DEPTH         = 64,
  parameter int POLL_INTERVAL = 250,
  parameter int POLL_LIMIT    = 1000,
  parameter int REV_W         = 8,
  localparam int AW           = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic             sh_we,
  input  logic [AW-1:0]    sh_addr,
  input  logic [DW-1:0]    sh_wdata,
  input  logic [AW-1:0]    fl_raddr,
  output logic [DW-1:0]    fl_rdata,
  input  logic             fl_hold,
  input  logic [REV_W-1:0] rev_id,
  input  logic             sec1_valid,
  output logic             busy,
  output logic             complete,
  output logic             timeout_err
);
  logic          req_q, req_d;
  logic          err_q, err_d;
  logic          eng_start, clr_req, timeout_set, seq_busy;
  logic          eng_done, done_sts, eng_we;
  logic [AW-1:0] eng_addr;
  logic [DW-1:0] sh_rdata;

  assign done_sts = eng_done & ~fl_hold;

  always_comb begin
    req_d = req_q;
    if (clr_req) begin
      req_d = 1'b0;
    end else if (csr_wr && csr_wdata[REQ_BIT] && !seq_busy) begin
      req_d = 1'b1;
    end
    err_d = err_q;
    if (timeout_set) begin
      err_d = 1'b1;
    end else if (csr_wr && csr_wdata[ERR_BIT]) begin
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      req_q <= req_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    csr_rdata           = '0;
    csr_rdata[REQ_BIT]  = req_q;
    csr_rdata[BUSY_BIT] = seq_busy;
    csr_rdata[SEC1_BIT] = sec1_valid;
    csr_rdata[DONE_BIT] = done_sts;
    csr_rdata[ERR_BIT]  = err_q;
  end

  flc_poll_seq #(
    .POLL_INTERVAL(POLL_INTERVAL),
    .POLL_LIMIT   (POLL_LIMIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_pend   (req_q),
    .done_sts   (done_sts),
    .rev_zero   (rev_id == '0),
    .sec1       (sec1_valid),
    .start      (eng_start),
    .clr_req    (clr_req),
    .busy       (seq_busy),
    .complete   (complete),
    .timeout_set(timeout_set)
  );

  flc_copy_engine #(.DEPTH(DEPTH), .AW(AW)) u_eng (
    .clk  (clk),
    .rst_n(rst_n),
    .start(eng_start),
    .hold (fl_hold),
    .addr (eng_addr),
    .wr_en(eng_we),
    .done (eng_done)
  );

  flc_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .REG_RD(1'b0)) u_shadow (
    .clk    (clk),
    .wr_en  (sh_we),
    .wr_addr(sh_addr),
    .wr_data(sh_wdata),
    .rd_addr(eng_addr),
    .rd_data(sh_rdata)
  );

  flc_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .REG_RD(1'b1)) u_flash (
    .clk    (clk),
    .wr_en  (eng_we),
    .wr_addr(eng_addr),
    .wr_data(sh_rdata),
    .rd_addr(fl_raddr),
    .rd_data(fl_rdata)
  );

  assign busy        = seq_busy;
  assign timeout_err = err_q;
endmodule

// File: rtl/flc_checker.sv
module flc_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic eng_done,
  input logic complete,
  input logic busy,
  input logic req_bit,
  input logic err,
  input logic err_clr_wr,
  input logic timeout_set
);
  // R4: a commit is only launched while the flash reports done
  p_start_when_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> eng_done);
  // R3: done falls once the copy is launched
  p_done_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !eng_done);
  // R2: the request bit self-clears when the copy starts
  p_req_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_bit);
  // R3: the completion pulse lasts one cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> !complete);
  // R3: the block is idle after completion
  p_idle_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> !busy);
  // R8: error stays set unless cleared by a write of 1
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr_wr) |=> err);
  // R4: a timeout always leaves the error flag set
  p_timeout_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_set |=> err);
endmodule

bind flash_commit_seq flc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (eng_start),
  .eng_done   (eng_done),
  .complete   (complete),
  .busy       (seq_busy),
  .req_bit    (req_q),
  .err        (err_q),
  .err_clr_wr (csr_wr && csr_wdata[flc_pkg::ERR_BIT]),
  .timeout_set(timeout_set)
);

// File: tb/flash_commit_seq_tb.sv
module flash_commit_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int IVL = 4;
  localparam int LIM = 4;
  localparam int REV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             csr_wr = 1'b0;
  logic [31:0]      csr_wdata = '0;
  logic [31:0]      csr_rdata;
  logic             sh_we = 1'b0;
  logic [AW-1:0]    sh_addr = '0;
  logic [DW-1:0]    sh_wdata = '0;
  logic [AW-1:0]    fl_raddr = '0;
  logic [DW-1:0]    fl_rdata;
  logic             fl_hold = 1'b0;
  logic [REV_W-1:0] rev_id = 8'd1;
  logic             sec1_valid = 1'b0;
  logic             busy, complete, timeout_err;

  int checks = 0;
  int errors = 0;
  int falls = 0;
  int cmpls = 0;
  int busy_cyc = 0;
  logic prev_done = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_commit_seq #(
    .DW(DW), .DEPTH(DEPTH), .POLL_INTERVAL(IVL), .POLL_LIMIT(LIM), .REV_W(REV_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .sh_we(sh_we), .sh_addr(sh_addr), .sh_wdata(sh_wdata),
    .fl_raddr(fl_raddr), .fl_rdata(fl_rdata), .fl_hold(fl_hold), .rev_id(rev_id),
    .sec1_valid(sec1_valid), .busy(busy), .complete(complete),
    .timeout_err(timeout_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && !csr_rdata[26]) falls++;
      if (complete) cmpls++;
      if (busy) busy_cyc++;
      prev_done = csr_rdata[26];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    falls = 0; cmpls = 0; busy_cyc = 0;
  endtask

  task automatic csr_write(input logic [31:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic load_shadow(input logic [DW-1:0] seed);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); sh_we = 1'b1; sh_addr = AW'(i); sh_wdata = seed ^ DW'(i * 16'h1111);
    end
    @(negedge clk); sh_we = 1'b0;
  endtask

  task automatic check_flash(input string req, input logic [DW-1:0] seed);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); fl_raddr = AW'(i);
      @(negedge clk);
      check(req, 32'(fl_rdata), 32'(seed ^ DW'(i * 16'h1111)));
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 done", 32'(csr_rdata[26]), 1);
    check("R1 req", 32'(csr_rdata[23]), 0);
    check("R1 busy", {30'd0, csr_rdata[24], busy}, 0);
    check("R1 err", {30'd0, csr_rdata[28], timeout_err}, 0);
    check("R1 complete", 32'(complete), 0);
  endtask

  task automatic t_basic(input logic [DW-1:0] seed);
    load_shadow(seed);
    clr_mon();
    csr_write(32'h1 << 23);
    check("R2 req set", 32'(csr_rdata[23]), 1);
    wait_idle();
    check("R2 req cleared", 32'(csr_rdata[23]), 0);
    check("R3 one pulse", 32'(cmpls), 1);
    check("R3 done fell once", 32'(falls), 1);
    check("R3 done back", 32'(csr_rdata[26]), 1);
    check("R3 no err", 32'(timeout_err), 0);
    check_flash("R3 flash image", seed);
  endtask

  task automatic t_rev(input logic [REV_W-1:0] rv, input logic s1, input int exp_falls,
                       input logic [DW-1:0] seed);
    rev_id = rv; sec1_valid = s1;
    load_shadow(seed);
    clr_mon();
    csr_write(32'h1 << 23);
    wait_idle();
    check("R7 sec1 mirror", 32'(csr_rdata[25]), 32'(s1));
    check("R7 commit count", 32'(falls), 32'(exp_falls));
    check("R7 one pulse", 32'(cmpls), 1);
    check_flash("R7 flash image", seed);
    rev_id = 8'd1; sec1_valid = 1'b0;
  endtask

  task automatic t_pre_timeout(input logic [DW-1:0] old_seed);
    @(negedge clk); fl_hold = 1'b1;
    load_shadow(16'hdead);
    clr_mon();
    csr_write(32'h1 << 23);
    wait_idle();
    check("R4 err set", 32'(timeout_err), 1);
    check("R4 no pulse", 32'(cmpls), 0);
    check("R4 no commit", 32'(falls), 0);
    check("R4 req cleared", 32'(csr_rdata[23]), 0);
    check("R5 busy cycles", 32'(busy_cyc), 32'((LIM - 1) * IVL + 1));
    @(negedge clk); fl_hold = 1'b0;
    repeat (4) @(negedge clk);
    check_flash("R4 flash unchanged", old_seed);
  endtask

  task automatic t_err_sticky();
    csr_write(32'h0);
    check("R8 err kept on write 0", 32'(timeout_err), 1);
    csr_write(32'h1 << 28);
    check("R8 err cleared", 32'(timeout_err), 0);
  endtask

  task automatic t_post_timeout(input logic [DW-1:0] seed);
    load_shadow(seed);
    clr_mon();
    csr_write(32'h1 << 23);
    for (int i = 0; i < 50; i++) begin
      if (!csr_rdata[26]) break;
      @(negedge clk);
    end
    fl_hold = 1'b1;
    wait_idle();
    check("R6 err set", 32'(timeout_err), 1);
    check("R6 no pulse", 32'(cmpls), 0);
    @(negedge clk); fl_hold = 1'b0;
    repeat (DEPTH + 4) @(negedge clk);
    check("R6 done after release", 32'(csr_rdata[26]), 1);
    check_flash("R6 flash image", seed);
    csr_write(32'h1 << 28);
  endtask

  task automatic t_busy_req(input logic [DW-1:0] seed);
    load_shadow(seed);
    clr_mon();
    csr_write(32'h1 << 23);
    repeat (3) @(negedge clk);
    check("R9 busy", 32'(busy), 1);
    csr_write(32'h1 << 23);
    wait_idle();
    repeat (30) @(negedge clk);
    check("R9 single op", 32'(cmpls), 1);
    check("R9 single commit", 32'(falls), 1);
    check("R9 idle", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic(16'h5a3c);
    t_rev(8'd0, 1'b1, 2, 16'h1234);
    t_rev(8'd0, 1'b0, 1, 16'h8001);
    t_rev(8'd2, 1'b1, 1, 16'h0ff0);
    t_pre_timeout(16'h0ff0);
    t_err_sticky();
    t_post_timeout(16'hc3a5);
    t_busy_req(16'h7777);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule